// File: doc/BRIEF.md
# Byte-Coded Accumulator-Style Processor Core

This block is a small processor core that completes one 8-bit instruction in every clock cycle. It presents a program counter on an instruction address port and decodes the byte that comes back on the same cycle. The program store sits outside the core. The core has six 8-bit working registers, named R0 to R5. An input port and an output port share a seventh register slot, so that copy instructions can move data to and from the outside world.

Several registers have fixed roles. R0 receives immediates and also holds the jump target. R1 and R2 are the operands of the arithmetic and logic unit. R3 receives the ALU result, and the branch conditions test its value. The two top bits of an instruction pick one of four classes: immediate load, calculate, copy and conditional jump.

Surrounding logic supplies the program bytes through the instruction port. It feeds data into the core through the input port, which is qualified by a read strobe. It collects results from the output port, which is qualified by a write strobe.

Top module: `byte_cpu_core`

## Requirements
- R1: Bits 7:6 of the instruction select its class: 00 immediate, 01 calculate, 10 copy, 11 condition. An immediate instruction writes its bits 5:0 into R0, with the upper bits of R0 set to zero.
- R2: A calculate instruction writes f(R1, R2) into R3, where bits 2:0 select f: 000 OR, 001 NAND, 010 NOR, 011 AND, 100 ADD, 101 SUB.
- R3: ADD keeps only the low 8 bits of the sum. SUB yields R1 minus R2, modulo 256.
- R4: Calculate codes 110 and 111 change no register.
- R5: A copy instruction reads the source given by bits 5:3 and writes the destination given by bits 2:0, where codes 0 to 5 mean R0 to R5. Source code 6 takes the value on the input port, and `in_rd` is high during the cycle in which that instruction is presented.
- R6: Destination code 6 sends the value to the output port. In the cycle after the copy executes, `out_wr` is high for exactly one cycle and `out_data` holds the copied value.
- R7: Source code 7 supplies zero, so the copy clears its destination.
- R8: Destination code 7 discards the value. No register changes and `out_wr` stays low.
- R9: A condition instruction reads R3 as a signed byte and tests it by bits 2:0: 000 never, 001 zero, 010 negative, 011 negative or zero, 100 always, 101 nonzero, 110 zero or positive, 111 strictly positive.
- R10: When the test passes, the program counter loads R0. For any other instruction, including a failed test, the program counter adds one and wraps from 255 to 0.
- R11: A synchronous reset sets the program counter, all six registers and `out_wr` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Program counter, used as the instruction address |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| in_data | input | 8 | Data value read by copies from source 6 |
| in_rd | output | 1 | High while the current instruction reads `in_data` |
| out_data | output | 8 | Last value copied to the output port |
| out_wr | output | 1 | One-cycle pulse marking a new `out_data` value |

## Verification
Each instruction is presented for one clock period and takes effect at the rising edge that ends that period. A register write therefore becomes visible to the next instruction. `imem_addr` changes at that same edge. `out_wr` and `out_data` rise just after the edge that executes the copy. `in_rd` is combinational and is valid during the period in which the reading instruction is presented.

The bench advances the core one edge at a time. It samples `in_rd` before the edge and samples the output port and `imem_addr` one nanosecond after it. Every result is reached through a short program that ends with a copy to the output port, so each check falls on a known edge.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

   localparam int unsigned INSTR_W = 8;
   localparam int unsigned FIELD_W = 3;
   localparam int unsigned IMM_W   = 6;

   localparam logic [FIELD_W-1:0] SLOT_PORT = 3'd6;
   localparam logic [FIELD_W-1:0] SLOT_NONE = 3'd7;

   localparam int unsigned IDX_IMM = 0;
   localparam int unsigned IDX_RES = 3;
   localparam int unsigned IDX_A   = 1;
   localparam int unsigned IDX_B   = 2;

   typedef enum logic [1:0] {
      CLS_IMM  = 2'b00,
      CLS_CALC = 2'b01,
      CLS_COPY = 2'b10,
      CLS_COND = 2'b11
   } instr_class_e;

   typedef enum logic [2:0] {
      ALU_OR   = 3'd0,
      ALU_NAND = 3'd1,
      ALU_NOR  = 3'd2,
      ALU_AND  = 3'd3,
      ALU_ADD  = 3'd4,
      ALU_SUB  = 3'd5,
      ALU_RSV6 = 3'd6,
      ALU_RSV7 = 3'd7
   } alu_op_e;

endpackage

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile
   import byte_cpu_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned NUM_REGS = 6
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [FIELD_W-1:0]               widx,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs[g] <= '0;
         end else if (we && (widx == FIELD_W'(g))) begin
            regs[g] <= wdata;
         end
      end
   end

endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
   import byte_cpu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  alu_op_e             op,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W-1:0]   result,
   output logic                valid
);

   always_comb begin
      valid  = 1'b1;
      result = '0;
      case (op)
         ALU_OR:   result = a | b;
         ALU_NAND: result = ~(a & b);
         ALU_NOR:  result = ~(a | b);
         ALU_AND:  result = a & b;
         ALU_ADD:  result = a + b;
         ALU_SUB:  result = a - b;
         default:  valid  = 1'b0;
      endcase
   end

endmodule

// File: rtl/byte_cpu_cond.sv
module byte_cpu_cond #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [2:0]         code,
   input  logic [DATA_W-1:0]  value,
   output logic               take
);

   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[DATA_W-1];

   always_comb begin
      case (code)
         3'd0:    take = 1'b0;
         3'd1:    take = is_zero;
         3'd2:    take = is_neg;
         3'd3:    take = is_neg | is_zero;
         3'd4:    take = 1'b1;
         3'd5:    take = ~is_zero;
         3'd6:    take = ~is_neg;
         default: take = ~is_neg & ~is_zero;
      endcase
   end

   // R9: a negative operand never satisfies the two non-negative tests
   always_comb begin
      if (is_neg && (code == 3'd6 || code == 3'd7)) begin
         assert_neg_blocks_pos_R9: assert (!take);
      end
   end

endmodule

// File: rtl/byte_cpu_core.sv
module byte_cpu_core
   import byte_cpu_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_REGS = 6
) (
   input  logic                clk,
   input  logic                rst,
   output logic [ADDR_W-1:0]   imem_addr,
   input  logic [INSTR_W-1:0]  imem_data,
   input  logic [DATA_W-1:0]   in_data,
   output logic                in_rd,
   output logic [DATA_W-1:0]   out_data,
   output logic                out_wr
);

   localparam int unsigned REGS_W = NUM_REGS * DATA_W;

   if (NUM_REGS < 4 || NUM_REGS > 6) begin : g_bad_regs
      $error("NUM_REGS must lie between 4 and 6");
   end
   if (DATA_W < IMM_W) begin : g_bad_data
      $error("DATA_W must hold an immediate field");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must not exceed DATA_W");
   end

   instr_class_e                cls;
   logic [FIELD_W-1:0]          f_src;
   logic [FIELD_W-1:0]          f_dst;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [DATA_W-1:0]           src_val;
   logic [DATA_W-1:0]           alu_res;
   logic                        alu_valid;
   logic                        cond_ok;
   logic                        jump_taken;
   logic                        rf_we;
   logic [FIELD_W-1:0]          rf_widx;
   logic [DATA_W-1:0]           rf_wdata;
   logic [ADDR_W-1:0]           pc;
   logic [ADDR_W-1:0]           jump_target;

   assign cls   = instr_class_e'(imem_data[7:6]);
   assign f_src = imem_data[5:3];
   assign f_dst = imem_data[2:0];

   byte_cpu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) rf_i (
      .clk   (clk),
      .rst   (rst),
      .we    (rf_we),
      .widx  (rf_widx),
      .wdata (rf_wdata),
      .regs  (regs)
   );

   byte_cpu_alu #(.DATA_W(DATA_W)) alu_i (
      .op     (alu_op_e'(imem_data[2:0])),
      .a      (regs[IDX_A]),
      .b      (regs[IDX_B]),
      .result (alu_res),
      .valid  (alu_valid)
   );

   byte_cpu_cond #(.DATA_W(DATA_W)) cond_i (
      .code  (imem_data[2:0]),
      .value (regs[IDX_RES]),
      .take  (cond_ok)
   );

   always_comb begin
      src_val = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (f_src == FIELD_W'(i)) src_val = regs[i];
      end
      if (f_src == SLOT_PORT) src_val = in_data;
   end

   always_comb begin
      rf_we    = 1'b0;
      rf_widx  = FIELD_W'(IDX_IMM);
      rf_wdata = '0;
      case (cls)
         CLS_IMM: begin
            rf_we    = 1'b1;
            rf_wdata = DATA_W'(imem_data[IMM_W-1:0]);
         end
         CLS_CALC: begin
            rf_we    = alu_valid;
            rf_widx  = FIELD_W'(IDX_RES);
            rf_wdata = alu_res;
         end
         CLS_COPY: begin
            rf_we    = (f_dst < FIELD_W'(NUM_REGS));
            rf_widx  = f_dst;
            rf_wdata = src_val;
         end
         default: rf_we = 1'b0;
      endcase
   end

   assign in_rd      = (cls == CLS_COPY) && (f_src == SLOT_PORT);
   assign jump_taken = (cls == CLS_COND) && cond_ok;

   if (ADDR_W == DATA_W) begin : g_full_target
      assign jump_target = regs[IDX_IMM];
   end else begin : g_narrow_target
      assign jump_target = regs[IDX_IMM][ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else if (jump_taken) begin
         pc <= jump_target;
      end else begin
         pc <= pc + ADDR_W'(1);
      end
   end

   assign imem_addr = pc;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_wr   <= 1'b0;
         out_data <= '0;
      end else begin
         out_wr <= (cls == CLS_COPY) && (f_dst == SLOT_PORT);
         if ((cls == CLS_COPY) && (f_dst == SLOT_PORT)) begin
            out_data <= src_val;
         end
      end
   end

   // R10: a sequential instruction moves the program counter on by one
   assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
      !jump_taken |=> imem_addr == ADDR_W'($past(imem_addr) + ADDR_W'(1)));

   // R10: a passing test lands on the value held in R0
   assert_jump_target_R10: assert property (@(posedge clk) disable iff (rst)
      jump_taken |=> imem_addr == $past(regs[IDX_IMM][ADDR_W-1:0]));

   // R1: immediate reaches R0 with upper bits zero
   assert_imm_load_R1: assert property (@(posedge clk) disable iff (rst)
      (imem_data[7:6] == 2'b00) |=> regs[IDX_IMM] == DATA_W'($past(imem_data[IMM_W-1:0])));

   // R6: an output pulse follows a copy to slot 6 and carries its source value
   assert_out_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      out_wr |-> ($past(imem_data[7:6]) == 2'b10) && ($past(imem_data[2:0]) == 3'd6)
                 && (out_data == $past(src_val)));

   // R4: reserved calculate codes leave the register file untouched
   assert_calc_rsv_R4: assert property (@(posedge clk) disable iff (rst)
      ((imem_data[7:6] == 2'b01) && (imem_data[2:1] == 2'b11)) |=> $stable(regs));

   // R8: discarding copy changes no register
   assert_copy_drop_R8: assert property (@(posedge clk) disable iff (rst)
      ((imem_data[7:6] == 2'b10) && (imem_data[2:0] == 3'd7)) |=> $stable(regs));

   logic [REGS_W-1:0] unused_regs_flat;
   assign unused_regs_flat = regs;

endmodule

// File: tb/byte_cpu_core_tb.sv
module byte_cpu_core_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] imem_addr;
   logic [7:0] imem_data;
   logic [7:0] in_data = 8'h00;
   logic       in_rd;
   logic [7:0] out_data;
   logic       out_wr;

   logic [7:0] prog [0:255];

   int checks = 0;
   int fails  = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   logic [7:0] last_out = 8'h00;

   always #2.5 clk = ~clk;

   assign imem_data = prog[imem_addr];

   byte_cpu_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .imem_addr (imem_addr),
      .imem_data (imem_data),
      .in_data   (in_data),
      .in_rd     (in_rd),
      .out_data  (out_data),
      .out_wr    (out_wr)
   );

   // op[18:16], operand a[15:8], operand b[7:0]
   localparam logic [18:0] VEC [10] = '{
      {3'd0, 8'hF0, 8'h0C},
      {3'd1, 8'hFF, 8'h0F},
      {3'd2, 8'h12, 8'h21},
      {3'd3, 8'h3C, 8'h0F},
      {3'd4, 8'hC8, 8'h64},
      {3'd4, 8'h01, 8'h02},
      {3'd5, 8'h05, 8'h07},
      {3'd5, 8'h80, 8'h01},
      {3'd6, 8'hAA, 8'h55},
      {3'd7, 8'h33, 8'h44}
   };

   function automatic logic [7:0] calc_expect(input logic [2:0] op,
                                              input logic [7:0] a,
                                              input logic [7:0] b);
      case (op)
         3'd0: return a | b;
         3'd1: return ~(a & b);
         3'd2: return ~(a | b);
         3'd3: return a & b;
         3'd4: return 8'((int'(a) + int'(b)) % 256);
         3'd5: return 8'((int'(a) - int'(b) + 256) % 256);
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit cond_expect(input logic [2:0] code, input logic [7:0] v);
      int s;
      s = (v >= 8'h80) ? int'(v) - 256 : int'(v);
      case (code)
         3'd0: return 1'b0;
         3'd1: return s == 0;
         3'd2: return s < 0;
         3'd3: return s <= 0;
         3'd4: return 1'b1;
         3'd5: return s != 0;
         3'd6: return s >= 0;
         default: return s > 0;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) prog[i] = 8'h00;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      @(posedge clk);
      @(posedge clk);
      #1;
      rst    = 1'b0;
      wr_cnt = 0;
      rd_cnt = 0;
   endtask

   task automatic step();
      if (in_rd) rd_cnt++;
      @(posedge clk);
      #1;
      if (out_wr) begin
         wr_cnt++;
         last_out = out_data;
      end
   endtask

   initial begin
      #1ms;
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R11: fill every register, then reset and read each back
      clear_prog();
      for (int i = 0; i < 6; i++) prog[i] = 8'hB0 | 8'(i);
      in_data = 8'h5A;
      do_reset();
      for (int i = 0; i < 6; i++) step();
      for (int i = 0; i < 6; i++) prog[i] = 8'h86 | 8'(i << 3);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check(imem_addr == 8'h00, "R11 pc in reset", imem_addr, 0);
      check(out_wr == 1'b0, "R11 out_wr in reset", out_wr, 0);
      do_reset();
      for (int i = 0; i < 6; i++) begin
         step();
         check(out_wr && out_data == 8'h00, "R11 register cleared", out_data, 0);
      end

      // R2 R3 R4: table of calculate vectors
      for (int v = 0; v < 10; v++) begin
         logic [2:0] op;
         logic [7:0] a;
         logic [7:0] b;
         op = VEC[v][18:16];
         a  = VEC[v][15:8];
         b  = VEC[v][7:0];
         clear_prog();
         prog[0] = 8'hB1;
         prog[1] = 8'hB2;
         prog[2] = 8'h40 | 8'(op);
         prog[3] = 8'h9E;
         do_reset();
         in_data = a;
         step();
         in_data = b;
         step();
         step();
         step();
         check(wr_cnt == 1 && last_out == calc_expect(op, a, b),
               (op >= 3'd6) ? "R4 reserved calc" : ((op >= 3'd4) ? "R3 add/sub" : "R2 logic op"),
               last_out, calc_expect(op, a, b));
      end

      // R1: immediates
      for (int k = 0; k < 2; k++) begin
         logic [7:0] imm;
         imm = (k == 0) ? 8'h3F : 8'h2A;
         clear_prog();
         prog[0] = imm;
         prog[1] = 8'h86;
         do_reset();
         step();
         step();
         check(wr_cnt == 1 && last_out == imm, "R1 immediate to R0", last_out, imm);
      end

      // R6: output pulse lasts one cycle
      clear_prog();
      prog[0] = 8'h15;
      prog[1] = 8'h86;
      do_reset();
      step();
      step();
      check(out_wr == 1'b1 && out_data == 8'h15, "R6 output write", out_data, 8'h15);
      step();
      check(out_wr == 1'b0, "R6 single pulse", out_wr, 0);
      check(out_data == 8'h15, "R6 data held", out_data, 8'h15);

      // R7: source 7 clears the destination
      clear_prog();
      prog[0] = 8'h05;
      prog[1] = 8'h84;
      prog[2] = 8'hBC;
      prog[3] = 8'hA6;
      do_reset();
      for (int i = 0; i < 4; i++) step();
      check(wr_cnt == 1 && last_out == 8'h00, "R7 zero source", last_out, 0);

      // R5 R8: input read into discarded destination
      clear_prog();
      prog[0] = 8'h09;
      prog[1] = 8'h85;
      prog[2] = 8'hB7;
      prog[3] = 8'hAE;
      do_reset();
      in_data = 8'h77;
      for (int i = 0; i < 4; i++) step();
      check(rd_cnt == 1, "R5 input strobe", rd_cnt, 1);
      check(wr_cnt == 1, "R8 no output write", wr_cnt, 1);
      check(last_out == 8'h09, "R8 registers unchanged", last_out, 8'h09);

      // R9 R10: every condition code against several R3 values
      for (int vi = 0; vi < 4; vi++) begin
         logic [7:0] r3v;
         case (vi)
            0: r3v = 8'h00;
            1: r3v = 8'h80;
            2: r3v = 8'h7F;
            default: r3v = 8'hFF;
         endcase
         for (int c = 0; c < 8; c++) begin
            logic [7:0] exp_out;
            clear_prog();
            prog[0]  = 8'hB3;
            prog[1]  = 8'h0A;
            prog[2]  = 8'hC0 | 8'(c);
            prog[3]  = 8'h01;
            prog[4]  = 8'h86;
            prog[10] = 8'h02;
            prog[11] = 8'h86;
            do_reset();
            in_data = r3v;
            for (int i = 0; i < 5; i++) step();
            exp_out = cond_expect(3'(c), r3v) ? 8'h02 : 8'h01;
            check(wr_cnt == 1 && last_out == exp_out, "R9 condition test", last_out, exp_out);
         end
      end

      // R10: jump to 255 and wrap back to 0
      clear_prog();
      prog[0]   = 8'hB0;
      prog[1]   = 8'hC4;
      prog[255] = 8'h07;
      do_reset();
      in_data = 8'hFF;
      step();
      check(imem_addr == 8'h01, "R10 increment", imem_addr, 1);
      step();
      check(imem_addr == 8'hFF, "R10 jump to R0", imem_addr, 8'hFF);
      step();
      check(imem_addr == 8'h00, "R10 wrap", imem_addr, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule